// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block runs the multi-step algorithms that a flash array needs to change its contents. A single start pulse, together with an operation select, an address and write data, launches either a program of one random-access location or an erase of the whole block that contains the address. The sequencer then drives the array through pulse and verify strobes. It retries each pulse until the array reports a passing verify or until a per-operation attempt limit runs out.

Erase has two phases. First, every location of the addressed block is programmed to all zeros, with its own verify and retry. Only then are erase pulses applied, each followed by a blank check of the block. A running erase can be parked at a verify decision point and continued later. Results appear in an 8-bit status byte that holds a ready flag, a suspended flag and three sticky error flags. A dedicated input clears the error flags.

The array is external. Program pulses clear the bits of `cellAddr` that are zero in `cellData`. An erase pulse acts on the block that contains `cellAddr`. The array answers each verify strobe on `verifyPass` one cycle later.

Top module: `flash_pe_seq`

## Requirements
- R1: After reset the status byte reads 0x80: bit 7 ready is 1, bits 6 to 0 are 0, and no strobe is active. Status bits 2 to 0 always read 0.
- R2: A program start (`opErase`=0) with permit and supply good issues one program pulse at `addr` with `wrData`, then a verify strobe. A passing verify ends the operation with status 0x80.
- R3: After each failing program verify, another program pulse and verify follow, so the number of pulses equals the number the cell needs, up to the limit.
- R4: When the verify after pulse number PROG_MAX still fails, status bit 4 (program error) is set and the sequencer returns to ready after exactly PROG_MAX pulses.
- R5: An erase start first programs each location of the addressed block (2^BLK_AW locations) to 0x00 with verify. Every erase pulse is issued only while the whole block reads zero, and locations outside the block are left untouched.
- R6: Each erase pulse is followed by a blank verify (`verifyBlank`=1). A pass ends the operation with status 0x80 and the block reads all ones.
- R7: When the blank verify after erase pulse number ERASE_MAX fails, status bit 5 (erase error) is set and the sequencer returns to ready after exactly ERASE_MAX erase pulses.
- R8: Status bit 7 reads 0 from the cycle after an accepted start until the operation ends. Strobes appear only while it reads 0.
- R9: A start while `permit` is low touches no array cell and sets bit 4 for a program or bit 5 for an erase.
- R10: A start while `supplyOk` is low touches no array cell and sets bit 3 (supply fault) together with the error bit of the requested operation.
- R11: A `suspendReq` during an erase parks the sequencer at the next verify decision. Status then reads ready with bit 6 set, and no strobes are issued. `resumeReq` continues the erase where it stopped.
- R12: `clrStatus` resets bits 5, 4 and 3 and leaves bits 7 and 6 alone. A set in the same cycle wins.
- R13: A start that arrives while an operation is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle operation launch |
| opErase | input | 1 | 1 = block erase, 0 = program |
| addr | input | AW | Target location (erase uses its block) |
| wrData | input | DW | Data to program |
| permit | input | 1 | Write permission from protection logic |
| supplyOk | input | 1 | Programming supply present |
| suspendReq | input | 1 | Request to park a running erase |
| resumeReq | input | 1 | Continue a parked erase |
| clrStatus | input | 1 | Clear the three error bits |
| verifyPass | input | 1 | Array verify result, one cycle after the strobe |
| cellAddr | output | AW | Array address for the current strobe |
| cellData | output | DW | Data to program or compare |
| progPulse | output | 1 | Program pulse strobe |
| erasePulse | output | 1 | Erase pulse strobe for the block of cellAddr |
| verifyStrobe | output | 1 | Verify request |
| verifyBlank | output | 1 | Verify is a whole-block blank check |
| status | output | 8 | {ready, suspended, eraseErr, progErr, supplyFault, 3'b0} |

## Verification
Programs are run from a vector table against cells that need 1, 3, PROG_MAX and PROG_MAX+1 pulses, and with all-zero and all-one data. This separates a retry loop that stops early, one that runs one pulse too many, and a limit compare that is off by one. Erases are run against blocks whose cells need a few pulses and against a block that never clears. A per-pulse check that the block is all zeros tells a missing or partial pre-program apart from a correct one. Neighbouring cells show whether the block range is wrong. Denied starts, a start that arrives while busy, and suspend and resume are each checked at the strobe outputs and the status byte.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PROG, S_PVER, S_PCHK,
    S_PPRG, S_PPVER, S_PPCHK,
    S_EPUL, S_EVER, S_ECHK, S_SUSP
  } seqState_t;

  typedef struct packed {
    logic latchReq;
    logic clrAtt;
    logic incAtt;
    logic clrLoc;
    logic incLoc;
    logic setSusp;
    logic clrSusp;
    logic setProgErr;
    logic setEraseErr;
    logic setSupplyErr;
    logic preMode;
    logic blankMode;
    logic progPulse;
    logic erasePulse;
    logic verify;
  } seqStrobe_t;

endpackage

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
  import flash_pe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       opErase,
  input  logic       permit,
  input  logic       supplyOk,
  input  logic       suspendReq,
  input  logic       resumeReq,
  input  logic       verifyPass,
  input  logic       atProgMax,
  input  logic       atEraseMax,
  input  logic       locLast,
  output seqStrobe_t st,
  output logic       busy
);

  seqState_t state, nxt, resumeSt, parkTarget;
  logic      goSusp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      resumeSt <= S_IDLE;
    end else begin
      state <= goSusp ? S_SUSP : nxt;
      if (goSusp) resumeSt <= parkTarget;
    end
  end

  always_comb begin
    st         = '0;
    nxt        = state;
    parkTarget = S_IDLE;
    goSusp     = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          if (!supplyOk) begin
            st.setSupplyErr = 1'b1;
            st.setProgErr   = ~opErase;
            st.setEraseErr  = opErase;
          end else if (!permit) begin
            st.setProgErr  = ~opErase;
            st.setEraseErr = opErase;
          end else begin
            st.latchReq = 1'b1;
            st.clrAtt   = 1'b1;
            st.clrLoc   = 1'b1;
            nxt         = opErase ? S_PPRG : S_PROG;
          end
        end
      end
      S_PROG: begin
        st.progPulse = 1'b1;
        st.incAtt    = 1'b1;
        nxt          = S_PVER;
      end
      S_PVER: begin
        st.verify = 1'b1;
        nxt       = S_PCHK;
      end
      S_PCHK: begin
        if (verifyPass) nxt = S_IDLE;
        else if (atProgMax) begin
          st.setProgErr = 1'b1;
          nxt           = S_IDLE;
        end else nxt = S_PROG;
      end
      S_PPRG: begin
        st.preMode   = 1'b1;
        st.progPulse = 1'b1;
        st.incAtt    = 1'b1;
        nxt          = S_PPVER;
      end
      S_PPVER: begin
        st.preMode = 1'b1;
        st.verify  = 1'b1;
        nxt        = S_PPCHK;
      end
      S_PPCHK: begin
        if (verifyPass) begin
          st.clrAtt = 1'b1;
          if (locLast) nxt = S_EPUL;
          else begin
            st.incLoc = 1'b1;
            nxt       = S_PPRG;
          end
        end else if (atProgMax) begin
          st.setEraseErr = 1'b1;
          nxt            = S_IDLE;
        end else nxt = S_PPRG;
        if (nxt != S_IDLE && suspendReq) begin
          goSusp     = 1'b1;
          parkTarget = nxt;
          st.setSusp = 1'b1;
        end
      end
      S_EPUL: begin
        st.erasePulse = 1'b1;
        st.incAtt     = 1'b1;
        nxt           = S_EVER;
      end
      S_EVER: begin
        st.verify    = 1'b1;
        st.blankMode = 1'b1;
        nxt          = S_ECHK;
      end
      S_ECHK: begin
        if (verifyPass) nxt = S_IDLE;
        else if (atEraseMax) begin
          st.setEraseErr = 1'b1;
          nxt            = S_IDLE;
        end else nxt = S_EPUL;
        if (nxt != S_IDLE && suspendReq) begin
          goSusp     = 1'b1;
          parkTarget = nxt;
          st.setSusp = 1'b1;
        end
      end
      S_SUSP: begin
        if (resumeReq) begin
          st.clrSusp = 1'b1;
          nxt        = resumeSt;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE) && (state != S_SUSP);

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.progPulse, st.erasePulse, st.verify}));

  // R8
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.progPulse || st.erasePulse || st.verify) |-> busy);

  // R9
  deny_stay_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && start && !permit) |=> (state == S_IDLE));

  // R11
  park_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SUSP) |-> !(st.progPulse || st.erasePulse || st.verify));

endmodule

// File: rtl/flash_pe_dpath.sv
module flash_pe_dpath
  import flash_pe_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int BLK_AW    = 4,
  parameter int PROG_MAX  = 25,
  parameter int ERASE_MAX = 1000
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqStrobe_t    st,
  input  logic          busy,
  input  logic          clrStatus,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output logic          atProgMax,
  output logic          atEraseMax,
  output logic          locLast,
  output logic [AW-1:0] cellAddr,
  output logic [DW-1:0] cellData,
  output logic [7:0]    status
);

  localparam int MAX_ATT = (PROG_MAX > ERASE_MAX) ? PROG_MAX : ERASE_MAX;
  localparam int ATT_W   = $clog2(MAX_ATT + 1);
  localparam int HI_W    = AW - BLK_AW;

  logic [AW-1:0]     addrLat;
  logic [DW-1:0]     dataLat;
  logic [BLK_AW-1:0] locCnt;
  logic [ATT_W-1:0]  attCnt;
  logic              suspFlag, eraseErr, progErr, supplyErr;
  logic [HI_W-1:0]   blockSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLat <= '0;
      dataLat <= '0;
      locCnt  <= '0;
      attCnt  <= '0;
    end else begin
      if (st.latchReq) begin
        addrLat <= addr;
        dataLat <= wrData;
      end
      if (st.clrLoc)      locCnt <= '0;
      else if (st.incLoc) locCnt <= locCnt + 1'b1;
      if (st.clrAtt)      attCnt <= '0;
      else if (st.incAtt) attCnt <= attCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      suspFlag  <= 1'b0;
      eraseErr  <= 1'b0;
      progErr   <= 1'b0;
      supplyErr <= 1'b0;
    end else begin
      if (st.setSusp)      suspFlag <= 1'b1;
      else if (st.clrSusp) suspFlag <= 1'b0;
      if (st.setEraseErr)  eraseErr <= 1'b1;
      else if (clrStatus)  eraseErr <= 1'b0;
      if (st.setProgErr)   progErr <= 1'b1;
      else if (clrStatus)  progErr <= 1'b0;
      if (st.setSupplyErr) supplyErr <= 1'b1;
      else if (clrStatus)  supplyErr <= 1'b0;
    end
  end

  assign atProgMax  = (attCnt == ATT_W'(PROG_MAX));
  assign atEraseMax = (attCnt == ATT_W'(ERASE_MAX));
  assign locLast    = &locCnt;
  assign blockSel   = addrLat[AW-1:BLK_AW];

  always_comb begin
    if (st.preMode) begin
      cellAddr = {blockSel, locCnt};
      cellData = '0;
    end else if (st.blankMode) begin
      cellAddr = {blockSel, {BLK_AW{1'b0}}};
      cellData = '1;
    end else begin
      cellAddr = addrLat;
      cellData = dataLat;
    end
  end

  assign status = {~busy, suspFlag, eraseErr, progErr, supplyErr, 3'b000};

  // R7
  att_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    attCnt <= ATT_W'(MAX_ATT));

  // R12
  clr_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrStatus && !st.setProgErr && !st.setEraseErr && !st.setSupplyErr)
      |=> (status[5:3] == 3'b000));

  // R11
  susp_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    suspFlag |-> !busy);

  // R5
  pre_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.preMode && !st.latchReq) |-> (cellAddr[AW-1:BLK_AW] == addrLat[AW-1:BLK_AW]));

endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
  import flash_pe_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int BLK_AW    = 4,
  parameter int PROG_MAX  = 25,
  parameter int ERASE_MAX = 1000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          opErase,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  input  logic          permit,
  input  logic          supplyOk,
  input  logic          suspendReq,
  input  logic          resumeReq,
  input  logic          clrStatus,
  input  logic          verifyPass,
  output logic [AW-1:0] cellAddr,
  output logic [DW-1:0] cellData,
  output logic          progPulse,
  output logic          erasePulse,
  output logic          verifyStrobe,
  output logic          verifyBlank,
  output logic [7:0]    status
);

  seqStrobe_t st;
  logic       busy, atProgMax, atEraseMax, locLast;

  flash_pe_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .opErase    (opErase),
    .permit     (permit),
    .supplyOk   (supplyOk),
    .suspendReq (suspendReq),
    .resumeReq  (resumeReq),
    .verifyPass (verifyPass),
    .atProgMax  (atProgMax),
    .atEraseMax (atEraseMax),
    .locLast    (locLast),
    .st         (st),
    .busy       (busy)
  );

  flash_pe_dpath #(
    .AW(AW), .DW(DW), .BLK_AW(BLK_AW),
    .PROG_MAX(PROG_MAX), .ERASE_MAX(ERASE_MAX)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .busy       (busy),
    .clrStatus  (clrStatus),
    .addr       (addr),
    .wrData     (wrData),
    .atProgMax  (atProgMax),
    .atEraseMax (atEraseMax),
    .locLast    (locLast),
    .cellAddr   (cellAddr),
    .cellData   (cellData),
    .status     (status)
  );

  assign progPulse    = st.progPulse;
  assign erasePulse   = st.erasePulse;
  assign verifyStrobe = st.verify;
  assign verifyBlank  = st.blankMode;

endmodule

// File: tb/tb_flash_pe_seq.sv
module tb_flash_pe_seq;

  localparam int AW = 8, DW = 8, BLK_AW = 4, PMAX = 5, EMAX = 7;
  localparam int BLK = 1 << BLK_AW;

  logic clk = 1'b0, rstN = 1'b0;
  logic start = 0, opErase = 0, permit = 1, supplyOk = 1;
  logic suspendReq = 0, resumeReq = 0, clrStatus = 0, verifyPass = 0;
  logic [AW-1:0] addr = '0, cellAddr;
  logic [DW-1:0] wrData = '0, cellData;
  logic progPulse, erasePulse, verifyStrobe, verifyBlank;
  logic [7:0] status;

  always #4 clk = ~clk;

  flash_pe_seq #(.AW(AW), .DW(DW), .BLK_AW(BLK_AW), .PROG_MAX(PMAX), .ERASE_MAX(EMAX)) dut (
    .clk(clk), .rstN(rstN), .start(start), .opErase(opErase), .addr(addr),
    .wrData(wrData), .permit(permit), .supplyOk(supplyOk), .suspendReq(suspendReq),
    .resumeReq(resumeReq), .clrStatus(clrStatus), .verifyPass(verifyPass),
    .cellAddr(cellAddr), .cellData(cellData), .progPulse(progPulse),
    .erasePulse(erasePulse), .verifyStrobe(verifyStrobe), .verifyBlank(verifyBlank),
    .status(status)
  );

  // behavioural array
  logic [DW-1:0] mem [1 << AW];
  int progResist = 0, eraseResist = 0;
  int progCnt = 0, eraseCnt = 0, strobeCnt = 0, badPre = 0;

  function automatic bit blockIs(input logic [AW-1:0] a, input logic [DW-1:0] v);
    for (int i = 0; i < BLK; i++)
      if (mem[{a[AW-1:BLK_AW], BLK_AW'(i)}] != v) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (progPulse || erasePulse || verifyStrobe) strobeCnt++;
    if (progPulse) begin
      progCnt++;
      if (progResist > 0) progResist--;
      else mem[cellAddr] = mem[cellAddr] & cellData;
    end
    if (erasePulse) begin
      eraseCnt++;
      if (!blockIs(cellAddr, '0)) badPre++;
      if (eraseResist > 0) eraseResist--;
      else for (int i = 0; i < BLK; i++) mem[{cellAddr[AW-1:BLK_AW], BLK_AW'(i)}] = '1;
    end
    if (verifyStrobe)
      verifyPass <= verifyBlank ? blockIs(cellAddr, '1) : (mem[cellAddr] == cellData);
  end

  int checks = 0, errors = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic launch(input bit er, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    opErase = er; addr = a; wrData = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitReady(input string req);
    int n = 0;
    while (!status[7] && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) check({req, " timeout"}, 0, 1);
  endtask

  task automatic clearFlags;
    @(negedge clk); clrStatus = 1'b1;
    @(negedge clk); clrStatus = 1'b0;
  endtask

  task automatic fillAll(input logic [DW-1:0] v);
    for (int i = 0; i < (1 << AW); i++) mem[i] = v;
  endtask

  // addr, data, resist, expected status, expected pulses, expected cell
  localparam logic [47:0] PVEC [5] = '{
    {8'h03, 8'hA5, 8'd0, 8'h80, 8'd1, 8'hA5},
    {8'h7E, 8'h3C, 8'd2, 8'h80, 8'd3, 8'h3C},
    {8'hC1, 8'h00, 8'd4, 8'h80, 8'd5, 8'h00},
    {8'h55, 8'h0F, 8'd5, 8'h90, 8'd5, 8'hFF},
    {8'hF0, 8'hFF, 8'd0, 8'h80, 8'd1, 8'hFF}
  };

  initial begin
    int base, sc;
    fillAll('1);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 status at reset", status, 8'h80);
    check("R1 no strobes at reset", {progPulse, erasePulse, verifyStrobe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 status after reset", status, 8'h80);

    // R2 R3 R4 program vectors
    for (int v = 0; v < 5; v++) begin
      fillAll('1);
      progResist = int'(PVEC[v][31:24]);
      base = progCnt;
      launch(1'b0, PVEC[v][47:40], PVEC[v][39:32]);
      check("R8 busy after start", status[7], 0);
      waitReady("R2");
      check("R2 R4 program status", status, PVEC[v][23:16]);
      check("R3 R4 program pulse count", progCnt - base, PVEC[v][15:8]);
      check("R2 cell content", mem[PVEC[v][47:40]], PVEC[v][7:0]);
      clearFlags();
      @(negedge clk);
      check("R12 status after clear", status, 8'h80);
    end

    // R5 R6 R13 erase with a start arriving while busy
    fillAll('1);
    for (int i = 0; i < BLK; i++) mem[8'h20 + i] = 8'(8'h11 * i);
    mem[8'h1F] = 8'h5A; mem[8'h30] = 8'h5A; mem[8'h00] = 8'hFF;
    progResist = 0; eraseResist = 3; badPre = 0;
    base = progCnt; sc = eraseCnt;
    launch(1'b1, 8'h27, 8'h00);
    repeat (4) @(negedge clk);
    launch(1'b0, 8'h00, 8'h00);
    waitReady("R6");
    check("R6 erase status", status, 8'h80);
    check("R6 block all ones", blockIs(8'h20, '1), 1);
    check("R6 erase pulse count", eraseCnt - sc, 4);
    check("R5 pre-program pulses", progCnt - base, BLK);
    check("R5 block zero at each erase pulse", badPre, 0);
    check("R5 neighbour below", mem[8'h1F], 8'h5A);
    check("R5 neighbour above", mem[8'h30], 8'h5A);
    check("R13 ignored start left cell", mem[8'h00], 8'hFF);

    // R7 erase limit
    eraseResist = 100; sc = eraseCnt;
    launch(1'b1, 8'h45, 8'h00);
    waitReady("R7");
    check("R7 erase error status", status, 8'hA0);
    check("R7 erase pulse count", eraseCnt - sc, EMAX);
    clearFlags();
    @(negedge clk);
    check("R12 erase error cleared", status, 8'h80);

    // R11 suspend and resume
    eraseResist = 5; sc = eraseCnt; badPre = 0;
    launch(1'b1, 8'h60, 8'h00);
    begin
      int n = 0;
      while (eraseCnt - sc < 2 && n < 5000) begin @(negedge clk); n++; end
      suspendReq = 1'b1;
      n = 0;
      while (!status[6] && n < 5000) begin @(negedge clk); n++; end
      suspendReq = 1'b0;
    end
    check("R11 suspended status", status, 8'hC0);
    base = strobeCnt;
    repeat (10) @(negedge clk);
    check("R11 no strobes while parked", strobeCnt - base, 0);
    clearFlags();
    check("R12 clear keeps suspend bit", status, 8'hC0);
    resumeReq = 1'b1;
    @(negedge clk);
    resumeReq = 1'b0;
    check("R11 busy after resume", status[7:6], 2'b00);
    waitReady("R11");
    check("R11 erase finished", status, 8'h80);
    check("R11 total erase pulses", eraseCnt - sc, 6);
    check("R11 block erased", blockIs(8'h60, '1), 1);

    // R9 permit low
    fillAll('1);
    permit = 1'b0; base = strobeCnt;
    launch(1'b0, 8'h10, 8'h00);
    repeat (4) @(negedge clk);
    check("R9 program denied status", status, 8'h90);
    launch(1'b1, 8'h10, 8'h00);
    repeat (4) @(negedge clk);
    check("R9 erase denied status", status, 8'hB0);
    check("R9 no strobes", strobeCnt - base, 0);
    check("R9 cell untouched", mem[8'h10], 8'hFF);
    permit = 1'b1;
    clearFlags();

    // R10 supply low
    supplyOk = 1'b0; base = strobeCnt;
    launch(1'b0, 8'h11, 8'h00);
    repeat (4) @(negedge clk);
    check("R10 supply fault on program", status, 8'h98);
    clearFlags();
    launch(1'b1, 8'h11, 8'h00);
    repeat (4) @(negedge clk);
    check("R10 supply fault on erase", status, 8'hA8);
    check("R10 no strobes", strobeCnt - base, 0);
    supplyOk = 1'b1;

    // R12 set wins over clear in the same cycle
    @(negedge clk);
    clrStatus = 1'b1; supplyOk = 1'b0; opErase = 1'b0; start = 1'b1;
    @(negedge clk);
    clrStatus = 1'b0; start = 1'b0; supplyOk = 1'b1;
    check("R12 set wins over clear", status, 8'h98);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule